// File: doc/BRIEF.md
# Tiled Binary Similarity Top-2 Filter

This block is the digital first stage of a binary attention scorer. It receives a tile of 16 binary key rows together with a binary query, one column segment at a time. For every row it counts the bit positions where query and key agree, turns that count into a signed score, and sums the scores of successive column segments when the key dimension is wider than one segment. When the last column segment of a key tile has been scored, only the two best rows of that tile are kept. The block emits their scores and global key indices, which a value-prefetch unit would use. Over many key tiles this produces a short candidate list for a later ranking stage instead of a full score vector.

Input beats are accepted with a valid/ready handshake. Each beat carries one query segment and the matching segment of all 16 keys. Scoring of one beat overlaps the loading of the next. Candidates leave on a plain valid stream, two consecutive cycles per key tile, with a flag on the final candidate of a run of tiles.

Top module: `binsim_top2`

## Requirements
- R1: After reset, `out_valid` and `out_last` are 0 and `in_ready` is 1.
- R2: A key of KEY_DIM bits (default 128) arrives as COLS = KEY_DIM/WIDTH beats (default 2), column segment c in beat c. Row r occupies `in_keys[r*WIDTH +: WIDTH]` and the query segment is `in_query`. Row r's score is 2*M - KEY_DIM, where M is the number of agreeing bits over all segments.
- R3: Every emitted score is even and lies in -KEY_DIM..+KEY_DIM: +128 for a key equal to the query, -128 for its complement.
- R4: Segment scores of the same rows are summed across the COLS beats of a key tile. The sum restarts at the first beat of every key tile.
- R5: Per key tile exactly two candidates are emitted, highest score first. The second has a score no greater than the first and a different row. Among equal scores the lower row index wins.
- R6: `out_index` = tile*16 + row, where tile counts completed key tiles from 0. The counter returns to 0 after a tile whose beats carried `in_last`=1.
- R7: If the final beat of a key tile is accepted at clock edge k, its first candidate is valid from edge k+1 and its second from edge k+2, on consecutive cycles.
- R8: `out_last` is 1 only with the second candidate of a tile flagged by `in_last`.
- R9: At the default sizes, beats offered on every cycle are all accepted with `in_ready` held high, and no candidate is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Beat can be taken this cycle |
| in_query | input | WIDTH | Query column segment |
| in_keys | input | ROWS*WIDTH | Key column segment of every row, row r at r*WIDTH |
| in_last | input | 1 | Beat belongs to the final key tile of a run |
| out_valid | output | 1 | Candidate present |
| out_score | output | $clog2(KEY_DIM)+2 | Signed candidate score |
| out_index | output | $clog2(MAX_TILES)+$clog2(ROWS) | Global key index |
| out_last | output | 1 | Final candidate of the run |

## Verification
Candidate emission and scoring of the next tile can fall in the same cycle. The second candidate of tile N leaves while the final segment of tile N+1 is summed and reloads the emitter at that same edge. The bench provokes this by streaming key tiles with no idle cycles between beats. It then judges the result by matching the complete candidate stream, in order, against a bench-side model, and by confirming that `in_ready` never dropped.

// File: rtl/binsim_top2.sv
module binsim_top2 #(
  parameter int ROWS      = 16,
  parameter int WIDTH     = 64,
  parameter int KEY_DIM   = 128,
  parameter int MAX_TILES = 64
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        in_valid,
  output logic                                        in_ready,
  input  logic [WIDTH-1:0]                            in_query,
  input  logic [ROWS*WIDTH-1:0]                       in_keys,
  input  logic                                        in_last,
  output logic                                        out_valid,
  output logic signed [$clog2(KEY_DIM)+1:0]           out_score,
  output logic [$clog2(MAX_TILES)+$clog2(ROWS)-1:0]   out_index,
  output logic                                        out_last
);
  localparam int COLS   = KEY_DIM / WIDTH;
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int TILE_W = $clog2(MAX_TILES);
  localparam int IDX_W  = TILE_W + ROW_W;
  localparam int SC_W   = $clog2(KEY_DIM) + 2;
  localparam int MC_W   = $clog2(WIDTH) + 1;

  logic                    seg_v, seg_last;
  logic [WIDTH-1:0]        seg_q;
  logic [ROWS*WIDTH-1:0]   seg_k;
  logic [COL_W-1:0]        seg_col, col_cnt;
  logic signed [SC_W-1:0]  acc [ROWS];
  logic signed [SC_W-1:0]  sum [ROWS];
  logic [MC_W-1:0]         mcnt [ROWS];
  logic [TILE_W-1:0]       tile_cnt;
  logic [1:0]              em_cnt;
  logic signed [SC_W-1:0]  em_s0, em_s1, s1, s2;
  logic [IDX_W-1:0]        em_i0, em_i1;
  logic [ROW_W-1:0]        b1, b2;
  logic                    em_last, seg_final, advance, accept;

  assign seg_final = seg_v && (seg_col == COL_W'(COLS - 1));
  assign advance   = seg_v && (!seg_final || em_cnt <= 2'd1);
  assign in_ready  = !seg_v || advance;
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_v   <= 1'b0;
      col_cnt <= '0;
    end else begin
      if (accept) begin
        seg_v    <= 1'b1;
        seg_q    <= in_query;
        seg_k    <= in_keys;
        seg_last <= in_last;
        seg_col  <= col_cnt;
        col_cnt  <= (col_cnt == COL_W'(COLS - 1)) ? '0 : col_cnt + COL_W'(1);
      end else if (advance) begin
        seg_v <= 1'b0;
      end
    end
  end

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      logic [WIDTH-1:0] agree;
      agree   = ~(seg_q ^ seg_k[r*WIDTH +: WIDTH]);
      mcnt[r] = '0;
      for (int b = 0; b < WIDTH; b++) mcnt[r] = mcnt[r] + MC_W'(agree[b]);
      sum[r] = ((seg_col == '0) ? SC_W'(0) : acc[r]) + SC_W'(2 * int'(mcnt[r]) - WIDTH);
    end
  end

  always_ff @(posedge clk) begin
    if (advance)
      for (int r = 0; r < ROWS; r++) acc[r] <= sum[r];
  end

  always_comb begin
    if (sum[1] > sum[0]) begin
      s1 = sum[1]; b1 = ROW_W'(1); s2 = sum[0]; b2 = ROW_W'(0);
    end else begin
      s1 = sum[0]; b1 = ROW_W'(0); s2 = sum[1]; b2 = ROW_W'(1);
    end
    for (int r = 2; r < ROWS; r++) begin
      if (sum[r] > s1) begin
        s2 = s1; b2 = b1; s1 = sum[r]; b1 = ROW_W'(r);
      end else if (sum[r] > s2) begin
        s2 = sum[r]; b2 = ROW_W'(r);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      em_cnt   <= 2'd0;
      em_last  <= 1'b0;
      tile_cnt <= '0;
    end else if (advance && seg_final) begin
      em_cnt   <= 2'd2;
      em_s0    <= s1;
      em_i0    <= {tile_cnt, b1};
      em_s1    <= s2;
      em_i1    <= {tile_cnt, b2};
      em_last  <= seg_last;
      tile_cnt <= seg_last ? '0 : tile_cnt + TILE_W'(1);
    end else if (em_cnt != 2'd0) begin
      em_cnt <= em_cnt - 2'd1;
    end
  end

  assign out_valid = (em_cnt != 2'd0);
  assign out_score = (em_cnt == 2'd2) ? em_s0 : em_s1;
  assign out_index = (em_cnt == 2'd2) ? em_i0 : em_i1;
  assign out_last  = em_last && (em_cnt == 2'd1);

  a_r3_score_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_score) >= -KEY_DIM && int'(out_score) <= KEY_DIM && !out_score[0]));

  a_r5_desc_order: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && em_cnt == 2'd1) |-> (int'(out_score) <= int'($past(out_score))));

  a_r6_same_tile: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && em_cnt == 2'd1) |->
      (out_index[IDX_W-1:ROW_W] == $past(out_index[IDX_W-1:ROW_W]) && out_index != $past(out_index)));

  a_r7_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (em_cnt == 2'd2) |=> out_valid);

  a_r8_last_second: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && $past(out_valid)));

  a_r9_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_v && !advance) |=> (seg_v && $stable(seg_q) && $stable(seg_col)));
endmodule

// File: tb/test_binsim_top2.sv
module test_binsim_top2;
  localparam int R = 16, W = 64, C = 2, KD = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_last = 1'b0;
  logic [W-1:0] in_query = '0;
  logic [R*W-1:0] in_keys = '0;
  logic out_valid, out_last;
  logic signed [8:0] out_score;
  logic [9:0] out_index;

  binsim_top2 i_binsim_top2 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_query(in_query), .in_keys(in_keys), .in_last(in_last), .out_valid(out_valid),
    .out_score(out_score), .out_index(out_index), .out_last(out_last));

  always #4 clk = ~clk;

  localparam int NV = 8;
  localparam int MODE [NV] = '{0, 1, 2, 3, 4, 5, 0, 0};
  localparam logic [63:0] SEED [NV] = '{64'h1234_5678_9ABC_DEF1, 64'h0F0F_3C3C_A5A5_7E7E,
    64'hDEAD_BEEF_0BAD_F00D, 64'h1357_9BDF_2468_ACE0, 64'h8000_0000_0000_0001,
    64'h5555_AAAA_3333_CCCC, 64'hCAFE_D00D_1111_2222, 64'h7777_0000_FFFF_1234};

  int checks = 0, fails = 0, stalls = 0, cyc = 0, exp_n = 0, got_n = 0, exp_tile = 0;
  logic [63:0] kq [C];
  logic [63:0] kk [R][C];
  int exp_s [64], exp_i [64], got_s [64], got_i [64];
  bit exp_l [64], got_l [64];
  string exp_tag [64];

  function automatic logic [63:0] mix(input logic [63:0] x);
    logic [63:0] y = x ^ 64'h9E37_79B9_7F4A_7C15;
    y = y ^ (y << 13); y = y ^ (y >> 7); y = y ^ (y << 17);
    return y;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic fill(input int mode, input logic [63:0] seed);
    kq[0] = mix(seed); kq[1] = mix(seed ^ 64'h00FF_00FF_00FF_00FF);
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) kk[r][c] = mix(seed ^ (64'(r * 2 + c + 1) * 64'h0000_0001_0000_0107));
    case (mode)
      1: for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) kk[r][c] = kq[c];
      2: for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) kk[r][c] = ~kq[c];
      3: begin kk[15] = kq; kk[9] = kq; kk[9][1] = kk[9][1] ^ 64'h8; end
      4: for (int r = 0; r < R; r++) begin
           kk[r][0] = kq[0] ^ ((64'h1 << (15 - r)) - 64'h1); kk[r][1] = kq[1];
         end
      5: begin kk[3] = kq; kk[5] = kq; kk[11] = kq; kk[5][0][0] = ~kk[5][0][0]; kk[11][0][0] = ~kk[11][0][0]; end
      default: ;
    endcase
  endtask

  task automatic send_tile(input bit last, input string tag);
    int sc [R];
    int b1, b2;
    for (int r = 0; r < R; r++) begin
      int m = 0;
      for (int c = 0; c < C; c++) for (int b = 0; b < W; b++) m += (kq[c][b] == kk[r][c][b]) ? 1 : 0;
      sc[r] = 2 * m - KD;
    end
    b1 = 0; b2 = -1;
    for (int r = 1; r < R; r++) if (sc[r] > sc[b1]) b1 = r;
    for (int r = 0; r < R; r++) if (r != b1 && (b2 < 0 || sc[r] > sc[b2])) b2 = r;
    exp_s[exp_n] = sc[b1]; exp_i[exp_n] = exp_tile * R + b1; exp_l[exp_n] = 1'b0; exp_tag[exp_n] = tag;
    exp_s[exp_n+1] = sc[b2]; exp_i[exp_n+1] = exp_tile * R + b2; exp_l[exp_n+1] = last; exp_tag[exp_n+1] = tag;
    exp_n += 2;
    exp_tile = last ? 0 : exp_tile + 1;
    for (int c = 0; c < C; c++) begin
      @(negedge clk);
      in_valid = 1'b1; in_last = last; in_query = kq[c];
      for (int r = 0; r < R; r++) in_keys[r*W +: W] = kk[r][c];
      while (!in_ready) begin stalls++; @(negedge clk); end
    end
  endtask

  always @(negedge clk)
    if (rst_n && out_valid && got_n < 64) begin
      got_s[got_n] = int'(out_score); got_i[got_n] = int'(out_index); got_l[got_n] = out_last;
      got_n++;
    end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(out_last == 1'b0, "R1 out_last", int'(out_last), 0);
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

    for (int v = 0; v < NV; v++) begin
      string tag;
      case (MODE[v]) 1, 2: tag = "R3"; 3: tag = "R4"; 4, 5: tag = "R5"; default: tag = "R2"; endcase
      fill(MODE[v], SEED[v]);
      send_tile(v == NV - 1, tag);
    end
    fill(0, 64'h2468_1357_0000_FFFF); send_tile(1'b0, "R6");
    fill(0, 64'h0101_0202_0303_0404); send_tile(1'b1, "R6");
    @(negedge clk); in_valid = 1'b0;
    check(stalls == 0, "R9 stall cycles", stalls, 0);
    repeat (6) @(negedge clk);

    fill(1, 64'h0);
    send_tile(1'b1, "R7");
    @(negedge clk); in_valid = 1'b0;
    check(out_valid == 1'b0, "R7 edge k", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1 && out_index == 10'd0, "R7 edge k+1", int'(out_index), 0);
    @(negedge clk);
    check(out_valid == 1'b1 && out_index == 10'd1 && out_last, "R7 edge k+2", int'(out_index), 1);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 drained", int'(out_valid), 0);
    repeat (3) @(negedge clk);

    check(got_n == exp_n, "R9 candidate count", got_n, exp_n);
    for (int n = 0; n < exp_n && n < got_n; n++) begin
      check(got_s[n] == exp_s[n], {exp_tag[n], " score"}, got_s[n], exp_s[n]);
      check(got_i[n] == exp_i[n], {exp_tag[n], " index"}, got_i[n], exp_i[n]);
      check(got_l[n] == exp_l[n], "R8 last flag", int'(got_l[n]), int'(exp_l[n]));
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule